// File: doc/BRIEF.md
# Remote Input Edge and Length Interrupt Unit

This block watches the serial input of an infrared-style remote-control path and turns three kinds of event into interrupts: a rising edge on the input, a falling edge on the input, and the expiry of a loadable data-length down-counter. The input is brought into the clock domain through a synchronizer chain, and edges are found by comparing the synchronized level with its value one cycle earlier. Each cause has an enable bit and a sticky flag. All flags are ORed onto a single request line that goes to the system interrupt controller. Software reads the flag register to find out which cause fired, and clears a flag by writing a 1 to it.

The down-counter has two uses. In transmit mode, software writes a length and the counter counts down once per enabled tick, so the underflow marks the end of the data length. In receive mode, a rising edge on the input reloads the counter from the length register and a falling edge stops it. The remaining count then gives the width of the received pulse, and an underflow before the falling edge signals a receive error.

A small register port with an address, a write strobe, write data and combinational read data gives access to the enable register, the flag register, the length register and the live count.

Top module: `rmt_evt_irq`

## Requirements
- R1: After reset, the enable, flag, length and count registers all read 0 and `irq` is low.
- R2: Address 0 holds the enables and address 1 holds the flags. In both registers, bit 0 is underflow, bit 1 is rising edge and bit 2 is falling edge. Bits 7 to 3 of these two registers read 0, so writing 0xFF to address 0 reads back 0x07. Address 2 holds the length and address 3 reads the live count.
- R3: With the rising-edge enable set, a low-to-high change of `rx_in` sets flag bit 1. The flag is visible after the third rising clock edge that samples the new level, and not after the second.
- R4: With the falling-edge enable set, a high-to-low change of `rx_in` sets flag bit 2 with the same latency as R3.
- R5: While an enable bit is 0, the matching flag never sets and that cause does not raise `irq`.
- R6: Writing 1 to a flag bit at address 1 clears it. Writing 0 leaves it unchanged.
- R7: If a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when at least one flag is set.
- R9: In transmit mode (`rx_mode` = 0), writing address 2 loads the counter with the written value. The counter then drops by one on each clock where `tick` is high and holds while `tick` is low.
- R10: When the counter decrements from 1 to 0, the underflow event fires once. The counter then stays at 0 with no further underflow. Loading 0 leaves the counter idle and fires no underflow.
- R11: In receive mode (`rx_mode` = 1), a rising-edge event reloads the counter from the length register and starts it, and the falling-edge event stops it. With `tick` held high, a pulse sampled high on P clocks leaves the count at length − P when P < length.
- R12: In receive mode, if the pulse lasts long enough for the counter to reach 0 first, the underflow flag sets and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial remote input, asynchronous to `clk` |
| rx_mode | input | 1 | 1 = receive (edges drive the counter), 0 = transmit (a length write drives the counter) |
| tick | input | 1 | Count enable for the length counter |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions assume that `rx_mode` changes only while the counter is idle, and that a register write holds its address and data steady for the clock in which the strobe is sampled. The stimulus reaches the mode switch through an explicit zero-length load, which parks the counter first. It drives every input on the falling clock edge, so each sampled value is stable around the rising edge. `rx_in` stays low through reset, and each input level is held for more cycles than the synchronizer needs, so every edge that is applied is seen exactly once.

// File: rtl/rmt_evt_pkg.sv
package rmt_evt_pkg;

   // register width seen on the access port
   localparam int REG_W  = 8;
   // number of interrupt causes
   localparam int NCAUSE = 3;

   // cause bit positions, shared by the enable and flag registers
   localparam int C_UF   = 0;
   localparam int C_RISE = 1;
   localparam int C_FALL = 2;

   // register addresses; enable and flag registers are adjacent
   localparam int unsigned RA_EN   = 0;
   localparam int unsigned RA_FLAG = 1;
   localparam int unsigned RA_LEN  = 2;
   localparam int unsigned RA_CNT  = 3;

   typedef logic [NCAUSE-1:0] cause_vec_t;

endpackage

// File: rtl/rmt_edge_sync.sv
module rmt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("rmt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin};
         last_q <= sh_q[TOP];
      end
   end

   // compare the synchronized level with its value one cycle earlier
   assign rise = sh_q[TOP] & ~last_q;
   assign fall = ~sh_q[TOP] & last_q;

endmodule

// File: rtl/rmt_len_counter.sv
module rmt_len_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_mode,
   input  logic             tick,
   input  logic             len_wr,
   input  logic [CNT_W-1:0] len_wdata,
   input  logic             rise,
   input  logic             fall,
   output logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] cnt,
   output logic             uf
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             run_q;
   logic             load;
   logic             stop;
   logic             dec;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      // receive: edges frame the count; transmit: the length write starts it
      load     = rx_mode ? rise : len_wr;
      load_val = rx_mode ? len : len_wdata;
      stop     = rx_mode & fall;
      dec      = run_q & tick & ~load;
      uf       = dec & (cnt == ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len   <= '0;
         cnt   <= '0;
         run_q <= 1'b0;
      end else begin
         if (len_wr) len <= len_wdata;
         if (load) begin
            cnt   <= load_val;
            run_q <= (load_val != '0);
         end else begin
            if (dec)        cnt   <= cnt - ONE;
            if (stop || uf) run_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rmt_irq_flags.sv
module rmt_irq_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] en,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags,
   output logic         req
);

   if (N < 1) begin : g_bad_n
      $error("rmt_irq_flags: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                f_q <= 1'b0;
         else if (evt[i] && en[i])  f_q <= 1'b1;   // set beats clear
         else if (clr[i])           f_q <= 1'b0;
      end
      assign flags[i] = f_q;
   end

   assign req = |flags;

endmodule

// File: rtl/rmt_evt_irq.sv
module rmt_evt_irq
   import rmt_evt_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in,
   input  logic              rx_mode,
   input  logic              tick,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("rmt_evt_irq: ADDR_W must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
      $error("rmt_evt_irq: CNT_W must be within 1..REG_W");
   end

   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(RA_EN);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(RA_FLAG);
   localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(RA_LEN);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(RA_CNT);

   logic        wr_en;
   logic        wr_flag;
   logic        len_wr;
   logic        rise;
   logic        fall;
   logic        uf;
   cause_vec_t  en_q;
   cause_vec_t  flag_q;
   cause_vec_t  evt;
   cause_vec_t  clr;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] cnt_q;

   assign wr_en   = reg_wr && (reg_addr == A_EN);
   assign wr_flag = reg_wr && (reg_addr == A_FLAG);
   assign len_wr  = reg_wr && (reg_addr == A_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= reg_wdata[NCAUSE-1:0];
   end

   rmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (rx_in),
      .rise  (rise),
      .fall  (fall)
   );

   rmt_len_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_mode   (rx_mode),
      .tick      (tick),
      .len_wr    (len_wr),
      .len_wdata (reg_wdata[CNT_W-1:0]),
      .rise      (rise),
      .fall      (fall),
      .len       (len_q),
      .cnt       (cnt_q),
      .uf        (uf)
   );

   always_comb begin
      evt         = '0;
      evt[C_UF]   = uf;
      evt[C_RISE] = rise;
      evt[C_FALL] = fall;
      clr         = wr_flag ? reg_wdata[NCAUSE-1:0] : '0;
   end

   rmt_irq_flags #(.N(NCAUSE)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .evt   (evt),
      .clr   (clr),
      .flags (flag_q),
      .req   (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_EN)        reg_rdata[NCAUSE-1:0] = en_q;
      else if (reg_addr == A_FLAG) reg_rdata[NCAUSE-1:0] = flag_q;
      else if (reg_addr == A_LEN)  reg_rdata[CNT_W-1:0]  = len_q;
      else if (reg_addr == A_CNT)  reg_rdata[CNT_W-1:0]  = cnt_q;
   end

endmodule

// File: rtl/rmt_evt_irq_chk.sv
module rmt_evt_irq_chk
   import rmt_evt_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_mode,
   input logic              tick,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [NCAUSE-1:0] wbits,
   input logic [NCAUSE-1:0] rbits,
   input logic              irq,
   input logic              flag_wr,
   input logic              len_wr,
   input logic [NCAUSE-1:0] en,
   input logic [NCAUSE-1:0] flags,
   input logic [NCAUSE-1:0] evt,
   input logic [CNT_W-1:0]  cnt
);

   for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
      // R5: a disabled cause never sets its flag
      p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!en[i] && !flags[i]) |=> !flags[i]);
      // R6: write-1 clears when no set event competes
      p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_wr && wbits[i] && !(evt[i] && en[i])) |=> !flags[i]);
      // R7: an enabled event always leaves the flag set
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] && en[i]) |=> flags[i]);
   end

   // R8: a set flag seen through the read port implies a raised request
   p_irq_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_addr == ADDR_W'(RA_FLAG)) && (rbits != '0)) |-> irq);

   // R9: transmit counter holds while tick is low
   p_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !rx_mode && !len_wr) |=> $stable(cnt));

   // R10: a zero count stays at zero until reloaded
   p_zero_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == '0) && !rx_mode && !len_wr) |=> (cnt == '0));

   // R10: underflow fires once, never on consecutive cycles
   p_uf_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt[C_UF] |=> !evt[C_UF]);

endmodule

bind rmt_evt_irq rmt_evt_irq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_mode  (rx_mode),
   .tick     (tick),
   .reg_addr (reg_addr),
   .wbits    (reg_wdata[rmt_evt_pkg::NCAUSE-1:0]),
   .rbits    (reg_rdata[rmt_evt_pkg::NCAUSE-1:0]),
   .irq      (irq),
   .flag_wr  (wr_flag),
   .len_wr   (len_wr),
   .en       (en_q),
   .flags    (flag_q),
   .evt      (evt),
   .cnt      (cnt_q)
);

// File: tb/rmt_evt_irq_test.sv
module rmt_evt_irq_test;

   localparam int ADDR_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_in = 1'b0;
   logic              rx_mode = 1'b0;
   logic              tick = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic [7:0]        reg_wdata = '0;
   logic [7:0]        reg_rdata;
   logic              irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   rmt_evt_irq #(.ADDR_W(ADDR_W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_in     (rx_in),
      .rx_mode   (rx_mode),
      .tick      (tick),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   always #4 clk = ~clk;   // 125 MHz

   // transmit-mode vectors: length, ticks applied, expected count, expected underflow flag
   typedef struct packed {
      logic [7:0] len;
      logic [8:0] ticks;
      logic [7:0] cnt;
      logic       uf;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      {8'd5,   9'd3,   8'd2,   1'b0},
      {8'd5,   9'd5,   8'd0,   1'b1},
      {8'd5,   9'd8,   8'd0,   1'b1},
      {8'd1,   9'd1,   8'd0,   1'b1},
      {8'd0,   9'd4,   8'd0,   1'b0},
      {8'd200, 9'd10,  8'd190, 1'b0},
      {8'd255, 9'd255, 8'd0,   1'b1},
      {8'd7,   9'd0,   8'd7,   1'b0}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   // combinational read, called just after a falling edge
   task automatic peek(input logic [ADDR_W-1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         peek(ADDR_W'(a), v);
         check("R1 reset reg", v, 8'h00);
      end
      check("R1 reset irq", {7'd0, irq}, 8'h00);

      // R2: enable register width
      wr(2'd0, 8'hFF);
      peek(2'd0, v);
      check("R2 enable readback", v, 8'h07);
      wr(2'd0, 8'h00);

      // table walk: transmit counter (R9, R10)
      foreach (VEC[k]) begin
         wr(2'd0, 8'h01);
         wr(2'd1, 8'h07);
         wr(2'd2, VEC[k].len);
         tick = 1'b1;
         repeat (int'(VEC[k].ticks)) @(negedge clk);
         tick = 1'b0;
         peek(2'd3, v);
         check("R9/R10 count", v, VEC[k].cnt);
         peek(2'd1, v);
         check("R10 underflow flag", v, {7'd0, VEC[k].uf});
         check("R8 irq follows flag", {7'd0, irq}, {7'd0, VEC[k].uf});
      end
      wr(2'd1, 8'h07);

      // R5: disabled edges leave no flag
      wr(2'd0, 8'h00);
      @(negedge clk); rx_in = 1'b1;
      repeat (5) @(negedge clk);
      peek(2'd1, v);
      check("R5 rise gated flag", v, 8'h00);
      check("R5 rise gated irq", {7'd0, irq}, 8'h00);
      rx_in = 1'b0;
      repeat (5) @(negedge clk);
      peek(2'd1, v);
      check("R5 fall gated flag", v, 8'h00);

      // R3: rising-edge latency
      wr(2'd0, 8'h06);
      rx_in = 1'b1;
      @(negedge clk); @(negedge clk);
      peek(2'd1, v);
      check("R3 not yet after two edges", v, 8'h00);
      @(negedge clk);
      peek(2'd1, v);
      check("R3 rise flag after three edges", v, 8'h02);
      check("R8 irq on rise", {7'd0, irq}, 8'h01);

      // R6: write-0 keeps, write-1 clears
      wr(2'd1, 8'h00);
      peek(2'd1, v);
      check("R6 write 0 keeps", v, 8'h02);
      wr(2'd1, 8'h02);
      peek(2'd1, v);
      check("R6 write 1 clears", v, 8'h00);
      check("R8 irq drops", {7'd0, irq}, 8'h00);

      // R4: falling edge
      rx_in = 1'b0;
      repeat (4) @(negedge clk);
      peek(2'd1, v);
      check("R4 fall flag", v, 8'h04);
      wr(2'd1, 8'h07);

      // R7: set and clear in the same cycle
      wr(2'd0, 8'h01);
      wr(2'd2, 8'd2);
      tick = 1'b1;
      @(negedge clk);               // count now 1
      reg_addr  = 2'd1;
      reg_wdata = 8'h01;
      reg_wr    = 1'b1;
      @(negedge clk);               // underflow and clear on the same edge
      reg_wr = 1'b0;
      tick   = 1'b0;
      peek(2'd1, v);
      check("R7 set wins over clear", v, 8'h01);
      wr(2'd1, 8'h01);
      peek(2'd1, v);
      check("R6 cleared afterwards", v, 8'h00);

      // R9: tick low holds the count
      wr(2'd2, 8'd9);
      repeat (5) @(negedge clk);
      peek(2'd3, v);
      check("R9 hold without tick", v, 8'd9);
      tick = 1'b1;
      repeat (4) @(negedge clk);
      tick = 1'b0;
      peek(2'd3, v);
      check("R9 four ticks", v, 8'd5);

      // R11: receive pulse width
      wr(2'd2, 8'd0);               // park the counter
      rx_mode = 1'b1;
      wr(2'd0, 8'h07);
      wr(2'd1, 8'h07);
      wr(2'd2, 8'd50);
      tick  = 1'b1;
      rx_in = 1'b1;
      repeat (12) @(negedge clk);
      rx_in = 1'b0;
      repeat (5) @(negedge clk);
      tick = 1'b0;
      peek(2'd3, v);
      check("R11 pulse width count", v, 8'd38);
      peek(2'd1, v);
      check("R11 edge flags no underflow", v, 8'h06);

      // R12: pulse longer than the length
      wr(2'd1, 8'h07);
      wr(2'd2, 8'd5);
      tick  = 1'b1;
      rx_in = 1'b1;
      repeat (9) @(negedge clk);
      rx_in = 1'b0;
      repeat (5) @(negedge clk);
      tick = 1'b0;
      peek(2'd3, v);
      check("R12 count stays zero", v, 8'd0);
      peek(2'd1, v);
      check("R12 underflow flag in receive", v, 8'h07);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule